// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block divides a fast input clock by an integer N = P·B + A, where P is the prescaler modulus (32 by default). It has three parts. A dual-modulus prescaler counts either P or P+1 input cycles. A swallow counter chooses between the two moduli. A main counter counts prescaler cycles and marks the end of each output period. A separate binary reference divider runs on the oscillator clock and divides it by R. Each divider emits a single-cycle pulse in its own clock domain, and both pulses go to a phase comparator downstream.

The swallow value A and the main value B are captured together at each period boundary. The ratio R is captured at each reference period boundary. A counter-hold input parks both dividers at their load point. The hold is synchronized separately into each clock domain. When the hold is released, both dividers start counting from the same defined state. This keeps the phase relation between the two pulse trains deterministic rather than random. A reset puts both domains into the held state.

The inputs must satisfy 3 ≤ B ≤ 2^MAIN_W−1, A ≤ B, and 2 ≤ R ≤ 2^REF_W−1. With the default widths the continuous feedback range is 992 to 32,767.

Top module: `pswal_divider`

## Requirements
- R1: The feedback output pulses once every P·B + A input clock cycles, with P = 2^PRE_W. Each pulse is exactly one input clock cycle wide.
- R2: In each feedback period the first A prescaler cycles are P+1 input cycles long and the remaining B−A are P long. The modulus selection changes only at a prescaler cycle boundary while counting.
- R3: When A equals B, every prescaler cycle of the period is P+1 long, so the period is (P+1)·B cycles.
- R4: A change on the swallow or main value does not alter the period in progress. It takes effect from the next feedback period.
- R5: The reference output pulses once every R reference clock cycles. Each pulse is exactly one reference cycle wide.
- R6: A change on the reference ratio does not alter the reference period in progress. It takes effect from the next reference period.
- R7: While the hold input is high, after SYNC_STAGES cycles of synchronization in each domain, neither output pulses. The counters sit at their load point and follow the current input values.
- R8: After hold is released, the first feedback pulse appears on the (N+SYNC_STAGES)-th input clock rising edge after release. The first reference pulse appears on the (R+SYNC_STAGES)-th reference rising edge after release. With the default SYNC_STAGES = 2 this is N+2 and R+2.
- R9: While rst_n is low, both outputs are low and both domains are in the held state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fin_clk | input | 1 | Fast input clock to be divided by N |
| ref_clk | input | 1 | Oscillator clock for the reference divider |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| hold | input | 1 | Counter hold, level, asynchronous to both clocks |
| swallow_cnt | input | SW_W | Swallow value A |
| main_cnt | input | MAIN_W | Main value B |
| ref_ratio | input | REF_W | Reference ratio R |
| fb_pulse | output | 1 | One-cycle pulse per feedback period (fin_clk domain) |
| ref_pulse | output | 1 | One-cycle pulse per reference period (ref_clk domain) |

## Verification
The bench builds the block with PRE_W = 2 (P = 4), SW_W = 2, MAIN_W = 5 and REF_W = 5. With these values the full swallow range 0 to 3, the case A = B, and the largest main value 31 all produce periods of a few dozen to 127 cycles. This lets the bench cover every period-boundary reload and the hold/release alignment in a short run. The two clocks are kept at unrelated periods. This exposes the separate synchronization of the hold in each domain and the fixed first-pulse latency that follows a release.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

    // Prescaler modulus selection: P or P+1 input cycles per prescaler cycle
    typedef enum logic {
        MOD_LOW  = 1'b0,
        MOD_HIGH = 1'b1
    } modsel_e;

    // Default geometry of the divider
    localparam int DEF_PRE_W   = 5;
    localparam int DEF_SW_W    = 5;
    localparam int DEF_MAIN_W  = 10;
    localparam int DEF_REF_W   = 10;
    localparam int DEF_SYNC    = 2;

endpackage

// File: rtl/pswal_sync.sv
module pswal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    // Resets to all ones: a reset places the domain in the held state.
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/pswal_prescaler.sv
module pswal_prescaler
    import pswal_pkg::*;
#(
    parameter int PRE_W = 5
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hold,
    input  modsel_e mod_sel,
    output logic    cycle_end
);
    localparam int P     = 1 << PRE_W;
    localparam int CNT_W = PRE_W + 1;
    localparam logic [CNT_W-1:0] LAST_LOW  = CNT_W'(P - 1);
    localparam logic [CNT_W-1:0] LAST_HIGH = CNT_W'(P);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        st_d      = st_q;
        cycle_end = 1'b0;
        last_cnt  = (mod_sel == MOD_HIGH) ? LAST_HIGH : LAST_LOW;
        if (hold) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == last_cnt) begin
            st_d.cnt  = '0;
            cycle_end = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pswal_swallow_ctrl.sv
module pswal_swallow_ctrl
    import pswal_pkg::*;
#(
    parameter int SW_W   = 5,
    parameter int MAIN_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              cycle_end,
    input  logic [SW_W-1:0]   swallow_in,
    input  logic [MAIN_W-1:0] main_in,
    output modsel_e           mod_sel,
    output logic              period_pulse
);
    typedef struct packed {
        logic [SW_W-1:0]   a_cnt;
        logic [MAIN_W-1:0] b_cnt;
        logic              pulse;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       last_cycle;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        last_cycle = (st_q.b_cnt == MAIN_W'(1));
        if (hold) begin
            // load point: follow the inputs
            st_d.a_cnt = swallow_in;
            st_d.b_cnt = main_in;
        end else if (cycle_end) begin
            if (last_cycle) begin
                st_d.pulse = 1'b1;
                st_d.a_cnt = swallow_in;
                st_d.b_cnt = main_in;
            end else begin
                st_d.b_cnt = st_q.b_cnt - MAIN_W'(1);
                if (st_q.a_cnt != '0) begin
                    st_d.a_cnt = st_q.a_cnt - SW_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mod_sel      = (st_q.a_cnt != '0) ? MOD_HIGH : MOD_LOW;
    assign period_pulse = st_q.pulse;
endmodule

// File: rtl/pswal_ref_div.sv
module pswal_ref_div #(
    parameter int REF_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [REF_W-1:0] ratio,
    output logic             period_pulse
);
    typedef struct packed {
        logic [REF_W-1:0] cnt;
        logic             pulse;
    } ref_state_t;

    ref_state_t       st_d, st_q;
    logic [REF_W-1:0] reload;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        reload     = ratio - REF_W'(1);
        if (hold) begin
            st_d.cnt = reload;
        end else if (st_q.cnt == '0) begin
            st_d.pulse = 1'b1;
            st_d.cnt   = reload;
        end else begin
            st_d.cnt = st_q.cnt - REF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign period_pulse = st_q.pulse;
endmodule

// File: rtl/pswal_divider.sv
module pswal_divider
    import pswal_pkg::*;
#(
    parameter int PRE_W       = DEF_PRE_W,
    parameter int SW_W        = DEF_SW_W,
    parameter int MAIN_W      = DEF_MAIN_W,
    parameter int REF_W       = DEF_REF_W,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic              fin_clk,
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [SW_W-1:0]   swallow_cnt,
    input  logic [MAIN_W-1:0] main_cnt,
    input  logic [REF_W-1:0]  ref_ratio,
    output logic              fb_pulse,
    output logic              ref_pulse
);
    logic    fin_hold_s;
    logic    ref_hold_s;
    logic    pre_tick;
    modsel_e mod_sel;

    pswal_sync #(.STAGES(SYNC_STAGES)) i_fin_sync (
        .clk   (fin_clk),
        .rst_n (rst_n),
        .din   (hold),
        .dout  (fin_hold_s)
    );

    pswal_sync #(.STAGES(SYNC_STAGES)) i_ref_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .din   (hold),
        .dout  (ref_hold_s)
    );

    pswal_prescaler #(.PRE_W(PRE_W)) i_prescaler (
        .clk       (fin_clk),
        .rst_n     (rst_n),
        .hold      (fin_hold_s),
        .mod_sel   (mod_sel),
        .cycle_end (pre_tick)
    );

    pswal_swallow_ctrl #(.SW_W(SW_W), .MAIN_W(MAIN_W)) i_ctrl (
        .clk          (fin_clk),
        .rst_n        (rst_n),
        .hold         (fin_hold_s),
        .cycle_end    (pre_tick),
        .swallow_in   (swallow_cnt),
        .main_in      (main_cnt),
        .mod_sel      (mod_sel),
        .period_pulse (fb_pulse)
    );

    pswal_ref_div #(.REF_W(REF_W)) i_ref_div (
        .clk          (ref_clk),
        .rst_n        (rst_n),
        .hold         (ref_hold_s),
        .ratio        (ref_ratio),
        .period_pulse (ref_pulse)
    );
endmodule

// File: rtl/pswal_divider_chk.sv
module pswal_divider_chk
    import pswal_pkg::*;
(
    input logic    fin_clk,
    input logic    ref_clk,
    input logic    rst_n,
    input logic    fin_hold_s,
    input logic    ref_hold_s,
    input logic    pre_tick,
    input modsel_e mod_sel,
    input logic    fb_pulse,
    input logic    ref_pulse
);
    // R1
    fb_one_cycle_chk: assert property (@(posedge fin_clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    // R1
    fb_after_tick_chk: assert property (@(posedge fin_clk) disable iff (!rst_n)
        $rose(fb_pulse) |-> $past(pre_tick));

    // R2
    modsel_steady_chk: assert property (@(posedge fin_clk) disable iff (!rst_n)
        (!pre_tick && !fin_hold_s) |=> $stable(mod_sel));

    // R5
    ref_one_cycle_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    // R7
    fb_hold_quiet_chk: assert property (@(posedge fin_clk) disable iff (!rst_n)
        fin_hold_s |=> !fb_pulse);

    // R7
    ref_hold_quiet_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ref_hold_s |=> !ref_pulse);

    // R9
    always_comb begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!fb_pulse && !ref_pulse);
        end
    end
endmodule

bind pswal_divider pswal_divider_chk i_pswal_chk (
    .fin_clk    (fin_clk),
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .fin_hold_s (fin_hold_s),
    .ref_hold_s (ref_hold_s),
    .pre_tick   (pre_tick),
    .mod_sel    (mod_sel),
    .fb_pulse   (fb_pulse),
    .ref_pulse  (ref_pulse)
);

// File: tb/test_pswal_divider.sv
module test_pswal_divider;
    localparam int FIN_PERIOD = 10;
    localparam int REF_PERIOD = 16;
    localparam int REF_OFFSET = 3;
    localparam int PRE_W  = 2;
    localparam int SW_W   = 2;
    localparam int MAIN_W = 5;
    localparam int REF_W  = 5;
    localparam int P      = 1 << PRE_W;
    localparam int LAT    = 2;

    logic              fin_clk, ref_clk, rst_n, hold;
    logic [SW_W-1:0]   swallow_cnt;
    logic [MAIN_W-1:0] main_cnt;
    logic [REF_W-1:0]  ref_ratio;
    logic              fb_pulse, ref_pulse;

    pswal_divider #(
        .PRE_W(PRE_W), .SW_W(SW_W), .MAIN_W(MAIN_W), .REF_W(REF_W), .SYNC_STAGES(LAT)
    ) i_pswal_divider (
        .fin_clk     (fin_clk),
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .hold        (hold),
        .swallow_cnt (swallow_cnt),
        .main_cnt    (main_cnt),
        .ref_ratio   (ref_ratio),
        .fb_pulse    (fb_pulse),
        .ref_pulse   (ref_pulse)
    );

    initial begin
        fin_clk = 1'b0;
        forever #(FIN_PERIOD / 2) fin_clk = ~fin_clk;
    end

    initial begin
        ref_clk = 1'b0;
        #(REF_OFFSET);
        forever #(REF_PERIOD / 2) ref_clk = ~ref_clk;
    end

    int    checks = 0;
    int    errors = 0;
    int    fb_q[$];
    string fb_tag[$];
    int    ref_q[$];
    string ref_tag[$];
    int    rel_tok = 0;
    bit    hold_chk = 1'b0;
    int    fb_hold_pulses = 0;
    int    ref_hold_pulses = 0;
    bit    done = 1'b0;

    // feedback monitor: counts rising edges, compares at falling edges
    int fb_cnt = 0;
    int fb_seen = 0;
    always @(fin_clk) begin
        if (fin_clk) begin
            if (rel_tok != fb_seen) begin
                fb_seen = rel_tok;
                fb_cnt  = 0;
            end
            fb_cnt++;
        end else if (fb_pulse === 1'b1) begin
            if (hold_chk) fb_hold_pulses++;
            if (fb_q.size() != 0) begin
                int    exp_v;
                string tg;
                exp_v = fb_q.pop_front();
                tg    = fb_tag.pop_front();
                checks++;
                if (fb_cnt != exp_v) begin
                    errors++;
                    $display("FAIL %s: feedback interval actual %0d expected %0d", tg, fb_cnt, exp_v);
                end
            end
            fb_cnt = 0;
        end
    end

    // reference monitor
    int ref_cnt = 0;
    int ref_seen = 0;
    always @(ref_clk) begin
        if (ref_clk) begin
            if (rel_tok != ref_seen) begin
                ref_seen = rel_tok;
                ref_cnt  = 0;
            end
            ref_cnt++;
        end else if (ref_pulse === 1'b1) begin
            if (hold_chk) ref_hold_pulses++;
            if (ref_q.size() != 0) begin
                int    exp_v;
                string tg;
                exp_v = ref_q.pop_front();
                tg    = ref_tag.pop_front();
                checks++;
                if (ref_cnt != exp_v) begin
                    errors++;
                    $display("FAIL %s: reference interval actual %0d expected %0d", tg, ref_cnt, exp_v);
                end
            end
            ref_cnt = 0;
        end
    end

    int cur_n;
    int cur_r;

    task automatic fb_push(input int v, input string tg);
        fb_q.push_back(v);
        fb_tag.push_back(tg);
    endtask

    task automatic ref_push(input int v, input string tg);
        ref_q.push_back(v);
        ref_tag.push_back(tg);
    endtask

    task automatic fb_idle();
        while (fb_q.size() != 0) @(negedge fin_clk);
        #2;
    endtask

    task automatic ref_idle();
        while (ref_q.size() != 0) @(negedge ref_clk);
        #2;
    endtask

    // new A/B: the running period keeps the old ratio (R4)
    task automatic fb_set(input int a, input int b, input int reps, input string tg);
        fb_idle();
        swallow_cnt = SW_W'(a);
        main_cnt    = MAIN_W'(b);
        fb_push(cur_n, "R4");
        cur_n = P * b + a;
        for (int i = 0; i < reps; i++) fb_push(cur_n, tg);
    endtask

    // new R: the running period keeps the old ratio (R6)
    task automatic ref_set(input int r, input int reps, input string tg);
        ref_idle();
        ref_ratio = REF_W'(r);
        ref_push(cur_r, "R6");
        cur_r = r;
        for (int i = 0; i < reps; i++) ref_push(cur_r, tg);
    endtask

    task automatic check_low(input string tg);
        checks++;
        if (fb_pulse !== 1'b0 || ref_pulse !== 1'b0) begin
            errors++;
            $display("FAIL %s: outputs actual %b%b expected 00", tg, fb_pulse, ref_pulse);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge fin_clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run actual hung expected completion");
        finish_run();
    end

    initial begin
        rst_n       = 1'b0;
        hold        = 1'b1;
        swallow_cnt = SW_W'(0);
        main_cnt    = MAIN_W'(3);
        ref_ratio   = REF_W'(5);
        cur_n       = P * 3;
        cur_r       = 5;
        // R9: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge fin_clk);
            check_low("R9");
        end
        #2;
        rst_n = 1'b1;
        repeat (6) @(negedge fin_clk);
        // R7: held after reset
        check_low("R7");
        #2;
        // release: first pulses at N+2 / R+2 (R8), then steady periods
        fb_push(cur_n + LAT, "R8");
        fb_push(cur_n, "R1");
        fb_push(cur_n, "R1");
        ref_push(cur_r + LAT, "R8");
        ref_push(cur_r, "R5");
        ref_push(cur_r, "R5");
        rel_tok++;
        hold = 1'b0;

        fb_set(3, 3, 2, "R3");     // A = B: all P+1, N = 15
        fb_set(2, 5, 2, "R2");     // mixed moduli, N = 22
        fb_set(3, 31, 1, "R1");    // largest B, N = 127
        fb_set(0, 31, 1, "R2");    // no swallow, N = 124
        fb_idle();

        ref_set(2, 3, "R5");       // smallest ratio
        ref_set(31, 1, "R6");      // largest ratio
        ref_set(7, 2, "R6");
        ref_idle();
        fb_idle();

        // R7: hold stops both outputs while inputs change
        @(negedge fin_clk);
        #2;
        hold = 1'b1;
        repeat (8) @(negedge fin_clk);
        #2;
        hold_chk    = 1'b1;
        swallow_cnt = SW_W'(1);
        main_cnt    = MAIN_W'(4);
        ref_ratio   = REF_W'(9);
        cur_n       = P * 4 + 1;
        cur_r       = 9;
        repeat (300) @(negedge fin_clk);
        #2;
        hold_chk = 1'b0;
        checks++;
        if (fb_hold_pulses != 0) begin
            errors++;
            $display("FAIL R7: feedback pulses in hold actual %0d expected 0", fb_hold_pulses);
        end
        checks++;
        if (ref_hold_pulses != 0) begin
            errors++;
            $display("FAIL R7: reference pulses in hold actual %0d expected 0", ref_hold_pulses);
        end

        // R8: release with values loaded during hold
        fb_push(cur_n + LAT, "R8");
        fb_push(cur_n, "R1");
        ref_push(cur_r + LAT, "R8");
        ref_push(cur_r, "R5");
        rel_tok++;
        hold = 1'b0;
        fb_idle();
        ref_idle();
        finish_run();
    end
endmodule